// File: doc/BRIEF.md
# Ping-Pong Isochronous Buffer Data Port

This block gives a host processor streamed access to two small on-chip isochronous buffers, buffer 0 and buffer 1. The processor first loads a byte count. It then writes an 8-bit command code that names one buffer and a direction. From then on it moves 16-bit words through a single data port. An internal byte pointer starts at word zero every time and steps forward on each access. There is no way to choose a start address.

When the pointer reaches the loaded byte count, the transfer is finished. The block raises an end-of-transfer flag and updates a per-buffer full bit. Any further accesses are dropped.

A separate millisecond timer swaps the active buffer at a programmable rate. The rate can be 0 to 15 ms. On each swap the block emits a one-cycle pulse, so the surrounding logic can move on to the other buffer.

Top module: `isoc_pingpong_port`

## Requirements
- R1: After reset, `rdata` is 0x0000, `eot_flag` is 0, `buf_full` is 2'b00, `act_buf` is 0, `swap_pulse` is 0 and the toggle rate is 0.
- R2: Command codes select a transfer as follows:
  - bit 7 set means write; bit 1 names the buffer.
  - Code 0x40 reads buffer 0, 0xC0 writes buffer 0, 0x42 reads buffer 1 and 0xC2 writes buffer 1.
  - Any code other than these four and 0x47/0xC7 leaves the port idle. While idle, reads return 0x0000 and writes are dropped.
- R3: Every transfer begins at word 0. Each read strobe (`data_re`) or write strobe (`data_we`) moves the pointer on by one word, which is 2 bytes. Words written in order read back in the same order.
- R4: The byte count is loaded with `bcnt_we` from `wdata[AW:0]`. A buffer command starts a transfer only if a nonzero count has been loaded since the last transfer started. Otherwise the port stays idle.
- R5: A transfer is complete once the pointer is at or past the count. With an odd count, the last word is still moved.
- R6: After completion, writes do not change the buffer, reads return 0x0000, and the pointer stays where it is.
- R7: The end-of-transfer flag behaves as follows:
  - `eot_flag` becomes 1 on the clock edge of the final access.
  - An `ack_we` strobe with `wdata[0]`=1 clears it.
  - An `ack_we` strobe with `wdata[0]`=0 has no effect.
  - If a set and a clear arrive in the same cycle, the set wins.
- R8: When a write transfer into buffer b completes, `buf_full[b]` is set. When a read transfer from buffer b completes, `buf_full[b]` is cleared.
- R9: Code 0xC7 followed by a data write stores `wdata[3:0]` as the toggle rate and restarts the millisecond timer. Code 0x47 followed by a read returns the rate zero-extended to 16 bits.
- R10: With a rate N other than 0, the N-th `tick_1ms` pulse after the last swap or rate write does two things on its clock edge. It flips `act_buf`, and it drives `swap_pulse` high for exactly one cycle. With a rate of 0, no swap ever happens.
- R11: The two buffers are independent: a transfer into one never alters the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command code strobe |
| cmd_code | input | 8 | Command code |
| bcnt_we | input | 1 | Byte count load strobe, value taken from `wdata` |
| data_we | input | 1 | Data port write strobe |
| data_re | input | 1 | Data port read strobe, pointer advances on the edge |
| ack_we | input | 1 | Flag acknowledge strobe, `wdata[0]`=1 clears `eot_flag` |
| wdata | input | DW | Write data, count or acknowledge value |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| rdata | output | DW | Data port read value, valid while `data_re` is high |
| eot_flag | output | 1 | End-of-transfer flag |
| buf_full | output | 2 | Per-buffer full bits |
| act_buf | output | 1 | Currently active buffer |
| swap_pulse | output | 1 | One-cycle pulse when `act_buf` changes |

## Verification
The streaming function is tried with several input patterns:
- An even count written and read back in the same buffer. This separates in-order pointer stepping from address reuse.
- An odd count. This separates rounding the last word up from dropping it.
- A longer pre-fill followed by a shorter overwrite with one surplus write. This shows whether the surplus write reaches the word past the count.
- A command issued with no count loaded, and a mid-transfer switch to an unrecognised code. These check the arming rule and the idle fallback.

For the timer, ticks are counted at a rate of 3, which exposes an off-by-one in the swap edge, and then at a rate of 0, which must stay silent.

// File: rtl/isoc_pingpong_port.sv
module isoc_pingpong_port #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [7:0]    cmd_code,
  input  logic          bcnt_we,
  input  logic          data_we,
  input  logic          data_re,
  input  logic          ack_we,
  input  logic [DW-1:0] wdata,
  input  logic          tick_1ms,
  output logic [DW-1:0] rdata,
  output logic          eot_flag,
  output logic [1:0]    buf_full,
  output logic          act_buf,
  output logic          swap_pulse
);
  localparam int DEPTH = 1 << AW;
  localparam int BW    = AW + 1;
  localparam int PW    = BW + 1;

  typedef enum logic [2:0] {M_IDLE, M_RD, M_WR, M_RATE_RD, M_RATE_WR} mode_t;

  mode_t         mode;
  logic          sel;
  logic          armed;
  logic [PW-1:0] ptr;
  logic [BW-1:0] bcnt;
  logic [3:0]    rate;
  logic [3:0]    ms_cnt;
  logic [DW-1:0] mem0 [DEPTH];
  logic [DW-1:0] mem1 [DEPTH];

  wire           is_buf    = (cmd_code & 8'h7D) == 8'h40;
  wire           is_rate   = (cmd_code & 8'h7F) == 8'h47;
  wire           xfer_done = ptr >= {1'b0, bcnt};
  wire           in_xfer   = (mode == M_RD) || (mode == M_WR);
  wire           acc       = in_xfer && !xfer_done &&
                             ((mode == M_RD) ? data_re : data_we);
  wire [PW-1:0]  nptr      = ptr + PW'(2);
  wire           fin       = acc && (nptr >= {1'b0, bcnt});
  wire [AW-1:0]  waddr     = ptr[AW:1];
  wire           rate_wr   = (mode == M_RATE_WR) && data_we;
  wire           hit       = tick_1ms && (rate != 4'd0) && (ms_cnt == 4'(rate - 4'd1));

  always_comb begin
    case (mode)
      M_RD:      rdata = xfer_done ? '0 : (sel ? mem1[waddr] : mem0[waddr]);
      M_RATE_RD: rdata = {{(DW-4){1'b0}}, rate};
      default:   rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (acc && mode == M_WR) begin
      if (sel) mem1[waddr] <= wdata;
      else     mem0[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode  <= M_IDLE;
      sel   <= 1'b0;
      armed <= 1'b0;
      ptr   <= '0;
      bcnt  <= '0;
    end else begin
      if (bcnt_we) begin
        bcnt  <= wdata[BW-1:0];
        armed <= wdata[BW-1:0] != '0;
      end
      if (acc) ptr <= nptr;
      if (cmd_we) begin
        if (is_buf) begin
          if (armed) begin
            mode  <= cmd_code[7] ? M_WR : M_RD;
            sel   <= cmd_code[1];
            ptr   <= '0;
            armed <= 1'b0;
          end else begin
            mode <= M_IDLE;
          end
        end else if (is_rate) begin
          mode <= cmd_code[7] ? M_RATE_WR : M_RATE_RD;
        end else begin
          mode <= M_IDLE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eot_flag <= 1'b0;
      buf_full <= 2'b00;
    end else begin
      if (fin) eot_flag <= 1'b1;
      else if (ack_we && wdata[0]) eot_flag <= 1'b0;
      if (fin) buf_full[sel] <= (mode == M_WR);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate       <= 4'd0;
      ms_cnt     <= 4'd0;
      act_buf    <= 1'b0;
      swap_pulse <= 1'b0;
    end else begin
      swap_pulse <= 1'b0;
      if (rate_wr) begin
        rate   <= wdata[3:0];
        ms_cnt <= 4'd0;
      end else if (tick_1ms && rate != 4'd0) begin
        if (hit) begin
          ms_cnt     <= 4'd0;
          act_buf    <= ~act_buf;
          swap_pulse <= 1'b1;
        end else begin
          ms_cnt <= ms_cnt + 4'd1;
        end
      end
    end
  end

  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && is_buf && armed) |=> (ptr == '0 && in_xfer)); // R3

  AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && xfer_done && !cmd_we) |=> $stable(ptr)); // R6

  AST_EOT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eot_flag) |-> $past(acc)); // R7

  AST_FULL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_full[0]) |-> $past(mode == M_WR && !sel)); // R8

  AST_SWAP_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    swap_pulse |-> (act_buf != $past(act_buf))); // R10

  AST_RATE0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == 4'd0) |=> !swap_pulse); // R10

endmodule

// File: tb/isoc_pingpong_port_bench.sv
`timescale 1ns/1ps
module isoc_pingpong_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0, bcnt_we = 1'b0, data_we = 1'b0, data_re = 1'b0, ack_we = 1'b0;
  logic        tick_1ms = 1'b0;
  logic [7:0]  cmd_code = 8'h00;
  logic [15:0] wdata = 16'h0000;
  logic [15:0] rdata;
  logic        eot_flag, act_buf, swap_pulse;
  logic [1:0]  buf_full;

  int total = 0, passed = 0;
  bit finished = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  isoc_pingpong_port u_isoc_pingpong_port (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_code(cmd_code), .bcnt_we(bcnt_we),
    .data_we(data_we), .data_re(data_re), .ack_we(ack_we), .wdata(wdata),
    .tick_1ms(tick_1ms), .rdata(rdata), .eot_flag(eot_flag), .buf_full(buf_full),
    .act_buf(act_buf), .swap_pulse(swap_pulse));

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    total++;
    if (act === exp) passed++;
    else $display("FAIL %s: actual %h expected %h", tag, act, exp);
  endtask

  always @(negedge clk) begin
    if (data_re) begin
      if (exp_q.size() == 0) begin
        total++;
        $display("FAIL scoreboard: actual %h expected <none>", rdata);
      end else begin
        check(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic step(); @(posedge clk); #1; endtask

  task automatic cmd(input logic [7:0] c);
    cmd_we = 1'b1; cmd_code = c; step(); cmd_we = 1'b0;
  endtask
  task automatic load(input logic [15:0] n);
    bcnt_we = 1'b1; wdata = n; step(); bcnt_we = 1'b0;
  endtask
  task automatic wr(input logic [15:0] d);
    data_we = 1'b1; wdata = d; step(); data_we = 1'b0;
  endtask
  task automatic rd(input logic [15:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    data_re = 1'b1; step(); data_re = 1'b0;
  endtask
  task automatic ack(input logic [15:0] v);
    ack_we = 1'b1; wdata = v; step(); ack_we = 1'b0;
  endtask
  task automatic tick();
    tick_1ms = 1'b1; step(); tick_1ms = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    check(rdata, 16'h0000, "R1 rdata");
    check({15'b0, eot_flag}, 16'h0, "R1 eot_flag");
    check({14'b0, buf_full}, 16'h0, "R1 buf_full");
    check({14'b0, act_buf, swap_pulse}, 16'h0, "R1 act_buf/swap");

    // pre-fill buffer 0 with five words, then overwrite four (R3, R6)
    load(16'd10); cmd(8'hC0);
    for (int i = 0; i < 5; i++) wr(16'hC000 + 16'(i));
    ack(16'h0001);
    load(16'd8); cmd(8'hC0);
    for (int i = 0; i < 4; i++) wr(16'hA000 + 16'(i));
    check({15'b0, eot_flag}, 16'h1, "R7 eot set at last write");
    check({14'b0, buf_full}, 16'h1, "R8 buf0 full after write");
    wr(16'hDEAD); // R6 surplus write dropped
    ack(16'h0000);
    check({15'b0, eot_flag}, 16'h1, "R7 ack with 0 no effect");
    ack(16'h0001);
    check({15'b0, eot_flag}, 16'h0, "R7 ack with 1 clears");

    load(16'd10); cmd(8'h40);
    for (int i = 0; i < 4; i++) rd(16'hA000 + 16'(i), "R3 in-order readback");
    rd(16'hC004, "R6 word past count untouched");
    rd(16'h0000, "R6 read after completion");
    check({14'b0, buf_full}, 16'h0, "R8 buf0 cleared after read");
    ack(16'h0001);

    // odd count into buffer 1 (R5, R11)
    load(16'd5); cmd(8'hC2);
    wr(16'hB000); wr(16'hB001);
    check({15'b0, eot_flag}, 16'h0, "R5 not done before last word");
    wr(16'hB002);
    check({15'b0, eot_flag}, 16'h1, "R5 odd count done after 3 words");
    check({14'b0, buf_full}, 16'h2, "R8 buf1 full");
    ack(16'h0001);
    load(16'd5); cmd(8'h42);
    rd(16'hB000, "R5 buf1 word0"); rd(16'hB001, "R5 buf1 word1"); rd(16'hB002, "R5 buf1 last word");
    rd(16'h0000, "R6 buf1 after done");
    load(16'd2); cmd(8'h40);
    rd(16'hA000, "R11 buf0 unchanged by buf1 writes");
    ack(16'h0001);

    // R4 command without a count load is ignored
    cmd(8'h40);
    rd(16'h0000, "R4 unarmed read idle");
    check({15'b0, eot_flag}, 16'h0, "R4 no eot when unarmed");

    // R2 unknown code ends a transfer
    load(16'd8); cmd(8'h40);
    rd(16'hA000, "R2 read started");
    cmd(8'h11);
    rd(16'h0000, "R2 unknown code idles port");

    // R9 toggle rate register
    cmd(8'hC7); wr(16'hFFF3);
    cmd(8'h47);
    rd(16'h0003, "R9 rate readback");

    // R10 swap timing
    tick(); tick();
    check({15'b0, act_buf}, 16'h0, "R10 no swap before third tick");
    check({15'b0, swap_pulse}, 16'h0, "R10 no pulse before third tick");
    tick();
    check({15'b0, act_buf}, 16'h1, "R10 act_buf flips on third tick");
    check({15'b0, swap_pulse}, 16'h1, "R10 swap pulse high");
    step();
    check({15'b0, swap_pulse}, 16'h0, "R10 swap pulse one cycle");
    cmd(8'hC7); wr(16'h0000);
    for (int i = 0; i < 5; i++) tick();
    check({15'b0, act_buf}, 16'h1, "R10 rate 0 never swaps");

    step();
    finished = 1'b1;
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", passed, total);
      $finish;
    end
  end
endmodule